// File: doc/BRIEF.md
# Fully associative translation buffer with page protection

This block is a unified translation lookaside buffer. It holds a parameterised number of entries (64 by default) and compares all of them at once against an incoming virtual address. Each entry maps its own page, and the page can be 1 KB, 4 KB, 64 KB or 1 MB. A matching entry yields a physical address. The access is then rated against the entry's two-bit protection key and dirty bit. Entries can be private to one address space or shared across all of them.

A lookup request carries a virtual address, a read/write flag, a privileged-mode flag, the current address-space identifier and a flag that turns identifier checking on. One cycle later the block returns a registered physical address and a three-bit outcome code. Software refills the buffer through a write port that replaces one whole entry per cycle. An asynchronous reset empties the buffer by clearing every valid bit.

Top module: `tlb_lookup`

## Requirements
- R1: While reset is asserted and after it is released, rsp_valid is 0 until a request is made, and until an entry is written every lookup reports a miss (code 1 for a read, 2 for a write) with rsp_pa equal to 0.
- R2: rsp_valid is 1 in the cycle after a clock edge that samples req_valid high, and 0 after an edge that samples it low; rsp_code and rsp_pa belong to that request.
- R3: Size code 0, 1, 2 and 3 give pages of 1 KB, 4 KB, 64 KB and 1 MB. An entry's range starts at its virtual page number shifted left by 10, with the bits below the page size cleared, and ends at that start plus page size minus one. Only addresses inside the range match.
- R4: An entry written with its valid bit at 0 never matches.
- R5: When req_asid_en is 1, an entry whose share bit is 0 matches only if its identifier equals req_asid. An entry whose share bit is 1 ignores the identifier. When req_asid_en is 0, the identifier is ignored for all entries.
- R6: On a single match, rsp_pa is the physical page number shifted left by 10 with the bits below the page size cleared, ORed with the address offset inside the page.
- R7: An unprivileged access (req_priv 0) to an entry whose protection key has bit 1 at 0 returns code 3 for a read and 4 for a write.
- R8: A write that passes the privilege check, to an entry whose protection key has bit 0 at 0, returns code 4.
- R9: A write that passes both protection checks, to an entry whose dirty bit is 0, returns code 5. All other accesses that pass return code 0.
- R10: When no entry matches, the code is 1 for a read and 2 for a write, and rsp_pa is 0.
- R11: When more than one entry matches, the code is 6 and rsp_pa is 0.
- R12: A write through the entry port takes effect at one clock edge. A lookup sampled at the same edge uses the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears all valid bits |
| req_valid | input | 1 | Lookup request |
| req_va | input | VA_W (32) | Virtual address |
| req_rw | input | 1 | 1 = write access, 0 = read |
| req_priv | input | 1 | 1 = privileged mode |
| req_asid | input | ASID_W (8) | Current address-space identifier |
| req_asid_en | input | 1 | Enables identifier comparison |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | IDX_W (6) | Entry index to write |
| wr_vpn | input | VA_W-10 (22) | Virtual page number |
| wr_ppn | input | PA_W-10 (22) | Physical page number |
| wr_asid | input | ASID_W (8) | Entry identifier |
| wr_valid | input | 1 | Entry valid bit |
| wr_size | input | 2 | Page size code |
| wr_share | input | 1 | Shared entry, bypasses identifier |
| wr_prot | input | 2 | Protection key: bit 1 user access, bit 0 writable |
| wr_dirty | input | 1 | Dirty bit |
| rsp_valid | output | 1 | Result valid, one cycle after request |
| rsp_pa | output | PA_W (32) | Physical address |
| rsp_code | output | 3 | 0 ok, 1 read miss, 2 write miss, 3 read violation, 4 write violation, 5 initial write, 6 multiple hit |

## Verification
The assertions assume that req_rw and req_priv are steady for the whole cycle in which req_valid is sampled. They also assume that no entry-write strobe happens before the first one whose valid bit is 1. Under these assumptions, the entry-free interval after reset is the only time when only misses are legal. The bench changes inputs only on falling edges and holds each request for exactly one rising edge. It fills entries in disjoint address regions, except where a test builds an overlap on purpose, so every expected code follows from a single, known entry.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

   typedef enum logic [2:0] {
      RES_OK       = 3'd0,
      RES_RD_MISS  = 3'd1,
      RES_WR_MISS  = 3'd2,
      RES_RD_VIOL  = 3'd3,
      RES_WR_VIOL  = 3'd4,
      RES_FIRST_WR = 3'd5,
      RES_MULTI    = 3'd6
   } tlb_res_e;

   // Page-number bits below the page size, for each size code.
   function automatic logic [9:0] page_low_mask(input logic [1:0] sz);
      case (sz)
         2'd0:    page_low_mask = 10'h000;
         2'd1:    page_low_mask = 10'h003;
         2'd2:    page_low_mask = 10'h03F;
         default: page_low_mask = 10'h3FF;
      endcase
   endfunction

endpackage

// File: rtl/tlb_store.sv
module tlb_store #(
   parameter int ENTRIES = 64,
   parameter int IDX_W   = 6,
   parameter int VPN_W   = 22,
   parameter int PPN_W   = 22,
   parameter int ASID_W  = 8
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [IDX_W-1:0]               wr_idx,
   input  logic [VPN_W-1:0]               wr_vpn,
   input  logic [PPN_W-1:0]               wr_ppn,
   input  logic [ASID_W-1:0]              wr_asid,
   input  logic                           wr_valid,
   input  logic [1:0]                     wr_size,
   input  logic                           wr_share,
   input  logic [1:0]                     wr_prot,
   input  logic                           wr_dirty,
   output logic [ENTRIES-1:0]             ent_valid,
   output logic [ENTRIES-1:0][VPN_W-1:0]  ent_vpn,
   output logic [ENTRIES-1:0][PPN_W-1:0]  ent_ppn,
   output logic [ENTRIES-1:0][ASID_W-1:0] ent_asid,
   output logic [ENTRIES-1:0][1:0]        ent_size,
   output logic [ENTRIES-1:0]             ent_share,
   output logic [ENTRIES-1:0][1:0]        ent_prot,
   output logic [ENTRIES-1:0]             ent_dirty
);

   for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      logic sel;
      assign sel = wr_en && (wr_idx == IDX_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   ent_valid[i] <= 1'b0;
         else if (sel) ent_valid[i] <= wr_valid;
      end

      always_ff @(posedge clk) begin
         if (sel) begin
            ent_vpn[i]   <= wr_vpn;
            ent_ppn[i]   <= wr_ppn;
            ent_asid[i]  <= wr_asid;
            ent_size[i]  <= wr_size;
            ent_share[i] <= wr_share;
            ent_prot[i]  <= wr_prot;
            ent_dirty[i] <= wr_dirty;
         end
      end
   end

endmodule

// File: rtl/tlb_cam.sv
module tlb_cam #(
   parameter int ENTRIES = 64,
   parameter int VPN_W   = 22,
   parameter int ASID_W  = 8
) (
   input  logic [VPN_W-1:0]               va_vpn,
   input  logic [ASID_W-1:0]              cur_asid,
   input  logic                           asid_en,
   input  logic [ENTRIES-1:0]             ent_valid,
   input  logic [ENTRIES-1:0][VPN_W-1:0]  ent_vpn,
   input  logic [ENTRIES-1:0][ASID_W-1:0] ent_asid,
   input  logic [ENTRIES-1:0][1:0]        ent_size,
   input  logic [ENTRIES-1:0]             ent_share,
   output logic [ENTRIES-1:0]             hit_vec
);

   for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
      logic [VPN_W-1:0] low;
      logic             asid_ok;
      logic             range_ok;

      assign low      = VPN_W'(tlb_pkg::page_low_mask(ent_size[i]));
      assign range_ok = ((va_vpn ^ ent_vpn[i]) & ~low) == '0;
      assign asid_ok  = ent_share[i] || !asid_en || (ent_asid[i] == cur_asid);
      assign hit_vec[i] = ent_valid[i] && asid_ok && range_ok;
   end

endmodule

// File: rtl/tlb_resolve.sv
module tlb_resolve #(
   parameter int ENTRIES          = 64,
   parameter int VPN_W            = 22,
   parameter int PPN_W            = 22,
   parameter bit MULTI_HIT_DETECT = 1'b1
) (
   input  logic [ENTRIES-1:0]             hit_vec,
   input  logic [VPN_W-1:0]               va_vpn,
   input  logic [9:0]                     va_off,
   input  logic                           acc_wr,
   input  logic                           acc_priv,
   input  logic [ENTRIES-1:0][PPN_W-1:0]  ent_ppn,
   input  logic [ENTRIES-1:0][1:0]        ent_size,
   input  logic [ENTRIES-1:0][1:0]        ent_prot,
   input  logic [ENTRIES-1:0]             ent_dirty,
   output logic [PPN_W+9:0]               pa,
   output tlb_pkg::tlb_res_e              code
);
   import tlb_pkg::*;

   localparam int CNT_W = $clog2(ENTRIES + 1);

   logic [ENTRIES-1:0] sel_vec;
   logic [CNT_W-1:0]   hit_cnt;
   logic               multi;
   logic [PPN_W-1:0]   s_ppn;
   logic [1:0]         s_size;
   logic [1:0]         s_prot;
   logic               s_dirty;
   logic [PPN_W-1:0]   low;
   logic [PPN_W-1:0]   va_low;

   always_comb begin
      hit_cnt = '0;
      for (int i = 0; i < ENTRIES; i++) hit_cnt = hit_cnt + CNT_W'(hit_vec[i]);
   end

   if (MULTI_HIT_DETECT) begin : g_detect
      assign sel_vec = hit_vec;
      assign multi   = hit_cnt > CNT_W'(1);
   end else begin : g_lowest
      assign sel_vec = hit_vec & (~hit_vec + ENTRIES'(1));
      assign multi   = 1'b0;
   end

   always_comb begin
      s_ppn   = '0;
      s_size  = '0;
      s_prot  = '0;
      s_dirty = 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (sel_vec[i]) begin
            s_ppn   = s_ppn | ent_ppn[i];
            s_size  = s_size | ent_size[i];
            s_prot  = s_prot | ent_prot[i];
            s_dirty = s_dirty | ent_dirty[i];
         end
      end
   end

   assign low    = PPN_W'(page_low_mask(s_size));
   assign va_low = PPN_W'(va_vpn[9:0]);

   always_comb begin
      pa = '0;
      if (hit_cnt == '0)
         code = acc_wr ? RES_WR_MISS : RES_RD_MISS;
      else if (multi)
         code = RES_MULTI;
      else begin
         pa = {(s_ppn & ~low) | (va_low & low), va_off};
         if (!acc_priv && !s_prot[1])
            code = acc_wr ? RES_WR_VIOL : RES_RD_VIOL;
         else if (acc_wr && !s_prot[0])
            code = RES_WR_VIOL;
         else if (acc_wr && !s_dirty)
            code = RES_FIRST_WR;
         else
            code = RES_OK;
      end
   end

endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup #(
   parameter int ENTRIES          = 64,
   parameter int IDX_W            = $clog2(ENTRIES),
   parameter int VA_W             = 32,
   parameter int PA_W             = 32,
   parameter int ASID_W           = 8,
   parameter bit MULTI_HIT_DETECT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [VA_W-1:0]   req_va,
   input  logic              req_rw,
   input  logic              req_priv,
   input  logic [ASID_W-1:0] req_asid,
   input  logic              req_asid_en,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [VA_W-11:0]  wr_vpn,
   input  logic [PA_W-11:0]  wr_ppn,
   input  logic [ASID_W-1:0] wr_asid,
   input  logic              wr_valid,
   input  logic [1:0]        wr_size,
   input  logic              wr_share,
   input  logic [1:0]        wr_prot,
   input  logic              wr_dirty,
   output logic              rsp_valid,
   output logic [PA_W-1:0]   rsp_pa,
   output logic [2:0]        rsp_code
);
   import tlb_pkg::*;

   localparam int VPN_W = VA_W - 10;
   localparam int PPN_W = PA_W - 10;

   if (ENTRIES < 1 || (1 << IDX_W) < ENTRIES) begin : g_bad_idx
      $error("tlb_lookup: IDX_W too narrow for ENTRIES");
   end
   if (VA_W < 21 || PA_W < 21) begin : g_bad_addr
      $error("tlb_lookup: address widths must cover a 1 MB page");
   end

   logic [ENTRIES-1:0]             ent_valid;
   logic [ENTRIES-1:0][VPN_W-1:0]  ent_vpn;
   logic [ENTRIES-1:0][PPN_W-1:0]  ent_ppn;
   logic [ENTRIES-1:0][ASID_W-1:0] ent_asid;
   logic [ENTRIES-1:0][1:0]        ent_size;
   logic [ENTRIES-1:0]             ent_share;
   logic [ENTRIES-1:0][1:0]        ent_prot;
   logic [ENTRIES-1:0]             ent_dirty;
   logic [ENTRIES-1:0]             hit_vec;
   logic [PA_W-1:0]                pa_d;
   tlb_res_e                       code_d;

   tlb_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .VPN_W(VPN_W),
               .PPN_W(PPN_W), .ASID_W(ASID_W)) u_store (
      .clk, .rst_n, .wr_en, .wr_idx, .wr_vpn, .wr_ppn, .wr_asid,
      .wr_valid, .wr_size, .wr_share, .wr_prot, .wr_dirty,
      .ent_valid, .ent_vpn, .ent_ppn, .ent_asid, .ent_size,
      .ent_share, .ent_prot, .ent_dirty
   );

   tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_cam (
      .va_vpn   (req_va[VA_W-1:10]),
      .cur_asid (req_asid),
      .asid_en  (req_asid_en),
      .ent_valid, .ent_vpn, .ent_asid, .ent_size, .ent_share,
      .hit_vec
   );

   tlb_resolve #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W),
                 .MULTI_HIT_DETECT(MULTI_HIT_DETECT)) u_resolve (
      .hit_vec,
      .va_vpn   (req_va[VA_W-1:10]),
      .va_off   (req_va[9:0]),
      .acc_wr   (req_rw),
      .acc_priv (req_priv),
      .ent_ppn, .ent_size, .ent_prot, .ent_dirty,
      .pa       (pa_d),
      .code     (code_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_pa    <= '0;
         rsp_code  <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_pa   <= pa_d;
            rsp_code <= code_d;
         end
      end
   end

endmodule

// File: rtl/tlb_lookup_chk.sv
module tlb_lookup_chk #(
   parameter int PA_W = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic            req_rw,
   input logic            req_priv,
   input logic            wr_en,
   input logic            wr_valid,
   input logic            rsp_valid,
   input logic [PA_W-1:0] rsp_pa,
   input logic [2:0]      rsp_code
);

   logic filled_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  filled_q <= 1'b0;
      else if (wr_en && wr_valid)  filled_q <= 1'b1;
   end

   p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   p_rsp_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   p_empty_misses_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !filled_q) |-> (rsp_code == 3'd1 || rsp_code == 3'd2));
   p_read_codes_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_rw) |=> (rsp_code inside {3'd0, 3'd1, 3'd3, 3'd6}));
   p_write_codes_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_rw) |=> (rsp_code inside {3'd0, 3'd2, 3'd4, 3'd5, 3'd6}));
   p_priv_no_rdviol_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_priv) |=> (rsp_code != 3'd3));
   p_pa_zero_nohit_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_code inside {3'd1, 3'd2, 3'd6}) |-> (rsp_pa == '0));

endmodule

bind tlb_lookup tlb_lookup_chk #(.PA_W(PA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_rw    (req_rw),
   .req_priv  (req_priv),
   .wr_en     (wr_en),
   .wr_valid  (wr_valid),
   .rsp_valid (rsp_valid),
   .rsp_pa    (rsp_pa),
   .rsp_code  (rsp_code)
);

// File: tb/tb_tlb_lookup.sv
module tb_tlb_lookup;

   localparam logic [2:0] C_OK = 3'd0, C_RMISS = 3'd1, C_WMISS = 3'd2,
                          C_RVIOL = 3'd3, C_WVIOL = 3'd4, C_FIRST = 3'd5,
                          C_MULTI = 3'd6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_va = '0;
   logic        req_rw = 1'b0;
   logic        req_priv = 1'b0;
   logic [7:0]  req_asid = '0;
   logic        req_asid_en = 1'b0;
   logic        wr_en = 1'b0;
   logic [5:0]  wr_idx = '0;
   logic [21:0] wr_vpn = '0;
   logic [21:0] wr_ppn = '0;
   logic [7:0]  wr_asid = '0;
   logic        wr_valid = 1'b0;
   logic [1:0]  wr_size = '0;
   logic        wr_share = 1'b0;
   logic [1:0]  wr_prot = '0;
   logic        wr_dirty = 1'b0;
   logic        rsp_valid;
   logic [31:0] rsp_pa;
   logic [2:0]  rsp_code;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   tlb_lookup dut (
      .clk, .rst_n, .req_valid, .req_va, .req_rw, .req_priv, .req_asid,
      .req_asid_en, .wr_en, .wr_idx, .wr_vpn, .wr_ppn, .wr_asid, .wr_valid,
      .wr_size, .wr_share, .wr_prot, .wr_dirty, .rsp_valid, .rsp_pa, .rsp_code
   );

   task automatic check_bit(string tag, logic got, logic exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0b expected=%0b", tag, got, exp);
      end
   endtask

   task automatic put(int idx, logic [21:0] vpn, logic [21:0] ppn, logic [7:0] asid,
                      logic v, logic [1:0] sz, logic sh, logic [1:0] pr, logic d);
      wr_idx = 6'(idx); wr_vpn = vpn; wr_ppn = ppn; wr_asid = asid;
      wr_valid = v; wr_size = sz; wr_share = sh; wr_prot = pr; wr_dirty = d;
      wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic look(string tag, logic [31:0] va, logic rw, logic priv,
                       logic [7:0] asid, logic en, logic [2:0] ecode, logic [31:0] epa);
      req_va = va; req_rw = rw; req_priv = priv; req_asid = asid; req_asid_en = en;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      checks++;
      if (rsp_valid !== 1'b1 || rsp_code !== ecode || rsp_pa !== epa) begin
         errors++;
         $display("FAIL %s va=%h: actual valid=%0b code=%0d pa=%h expected valid=1 code=%0d pa=%h",
                  tag, va, rsp_valid, rsp_code, rsp_pa, ecode, epa);
      end
   endtask

   task automatic t_reset;
      check_bit("R1 rsp_valid after reset", rsp_valid, 1'b0);
      look("R1 empty read", 32'h0001_2000, 1'b0, 1'b1, 8'h0, 1'b0, C_RMISS, 32'h0);
      look("R1 empty write", 32'h0040_0000, 1'b1, 1'b1, 8'h0, 1'b0, C_WMISS, 32'h0);
      @(negedge clk);
      check_bit("R2 idle drops rsp_valid", rsp_valid, 1'b0);
   endtask

   task automatic t_sizes;
      put(0, 22'h4B,   22'h155,   8'h0, 1, 2'd1, 1, 2'd3, 1);
      put(1, 22'h10FF, 22'h23456, 8'h0, 1, 2'd3, 1, 2'd3, 1);
      put(2, 22'h100,  22'h3,     8'h0, 1, 2'd0, 1, 2'd3, 1);
      put(3, 22'h2000, 22'h41,    8'h0, 1, 2'd2, 1, 2'd3, 1);
      look("R3 R6 4KB top", 32'h0001_2FFC, 0, 1, 8'h0, 1, C_OK, 32'h0005_5FFC);
      look("R3 4KB above", 32'h0001_3000, 0, 1, 8'h0, 1, C_RMISS, 32'h0);
      look("R3 4KB below", 32'h0001_1FFF, 0, 1, 8'h0, 1, C_RMISS, 32'h0);
      look("R3 R6 1MB", 32'h004A_BCDE, 0, 1, 8'h0, 1, C_OK, 32'h08DA_BCDE);
      look("R3 1MB above", 32'h0050_0000, 1, 1, 8'h0, 1, C_WMISS, 32'h0);
      look("R3 R6 1KB", 32'h0004_03FF, 0, 1, 8'h0, 1, C_OK, 32'h0000_0FFF);
      look("R3 1KB above", 32'h0004_0400, 0, 1, 8'h0, 1, C_RMISS, 32'h0);
      look("R3 R6 64KB", 32'h0080_FFFF, 0, 1, 8'h0, 1, C_OK, 32'h0001_FFFF);
      look("R3 64KB above", 32'h0081_0000, 0, 1, 8'h0, 1, C_RMISS, 32'h0);
   endtask

   task automatic t_invalid;
      put(4, 22'h400, 22'h9, 8'h0, 0, 2'd0, 1, 2'd3, 1);
      look("R4 invalid entry", 32'h0010_0000, 0, 1, 8'h0, 0, C_RMISS, 32'h0);
   endtask

   task automatic t_asid;
      put(5, 22'h800, 22'h10, 8'h12, 1, 2'd0, 0, 2'd3, 1);
      put(6, 22'h804, 22'h20, 8'h55, 1, 2'd0, 1, 2'd3, 1);
      look("R5 asid equal", 32'h0020_0004, 0, 1, 8'h12, 1, C_OK, 32'h0000_4004);
      look("R5 asid differs", 32'h0020_0004, 0, 1, 8'h13, 1, C_RMISS, 32'h0);
      look("R5 asid check off", 32'h0020_0004, 0, 1, 8'h13, 0, C_OK, 32'h0000_4004);
      look("R5 shared entry", 32'h0020_1008, 0, 1, 8'h13, 1, C_OK, 32'h0000_8008);
   endtask

   task automatic t_protect;
      put(7,  22'hC00, 22'h100, 8'h0, 1, 2'd0, 1, 2'd2, 1);
      put(8,  22'hC01, 22'h101, 8'h0, 1, 2'd0, 1, 2'd1, 1);
      put(9,  22'hC02, 22'h102, 8'h0, 1, 2'd0, 1, 2'd3, 0);
      put(10, 22'hC03, 22'h103, 8'h0, 1, 2'd0, 1, 2'd0, 1);
      look("R8 user read ro", 32'h0030_0010, 0, 0, 8'h0, 1, C_OK, 32'h0004_0010);
      look("R8 user write ro", 32'h0030_0010, 1, 0, 8'h0, 1, C_WVIOL, 32'h0004_0010);
      look("R8 priv write ro", 32'h0030_0010, 1, 1, 8'h0, 1, C_WVIOL, 32'h0004_0010);
      look("R7 user read priv-only", 32'h0030_0410, 0, 0, 8'h0, 1, C_RVIOL, 32'h0004_0410);
      look("R7 user write priv-only", 32'h0030_0410, 1, 0, 8'h0, 1, C_WVIOL, 32'h0004_0410);
      look("R7 priv read priv-only", 32'h0030_0410, 0, 1, 8'h0, 1, C_OK, 32'h0004_0410);
      look("R9 priv write dirty", 32'h0030_0410, 1, 1, 8'h0, 1, C_OK, 32'h0004_0410);
      look("R9 first write clean", 32'h0030_0820, 1, 0, 8'h0, 1, C_FIRST, 32'h0004_0820);
      look("R9 read clean", 32'h0030_0820, 0, 0, 8'h0, 1, C_OK, 32'h0004_0820);
      look("R7 user write key0", 32'h0030_0C00, 1, 0, 8'h0, 1, C_WVIOL, 32'h0004_0C00);
      look("R8 priv write key0", 32'h0030_0C00, 1, 1, 8'h0, 1, C_WVIOL, 32'h0004_0C00);
   endtask

   task automatic t_multi;
      put(11, 22'h1010, 22'h77, 8'h0, 1, 2'd0, 1, 2'd3, 1);
      look("R11 overlap read", 32'h0040_4010, 0, 1, 8'h0, 1, C_MULTI, 32'h0);
      look("R11 overlap write", 32'h0040_4010, 1, 1, 8'h0, 1, C_MULTI, 32'h0);
      look("R11 single in 1MB", 32'h0040_5000, 0, 1, 8'h0, 1, C_OK, 32'h08D0_5000);
   endtask

   task automatic t_same_cycle;
      wr_idx = 6'd2; wr_vpn = 22'h100; wr_ppn = 22'h7; wr_asid = 8'h0;
      wr_valid = 1; wr_size = 2'd0; wr_share = 1; wr_prot = 2'd3; wr_dirty = 1;
      wr_en = 1'b1;
      req_va = 32'h0004_0010; req_rw = 0; req_priv = 1; req_asid = 0; req_asid_en = 1;
      req_valid = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; req_valid = 1'b0;
      checks++;
      if (rsp_code !== C_OK || rsp_pa !== 32'h0000_0C10) begin
         errors++;
         $display("FAIL R12 same-cycle lookup: actual code=%0d pa=%h expected code=0 pa=00000c10",
                  rsp_code, rsp_pa);
      end
      look("R12 after rewrite", 32'h0004_0010, 0, 1, 8'h0, 1, C_OK, 32'h0000_1C10);
      put(2, 22'h100, 22'h7, 8'h0, 0, 2'd0, 1, 2'd3, 1);
      look("R12 R4 invalidated", 32'h0004_0010, 0, 1, 8'h0, 1, C_RMISS, 32'h0);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         $display("FAIL R2 watchdog: actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      check_bit("R1 rsp_valid in reset", rsp_valid, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_sizes();
      t_invalid();
      t_asid();
      t_protect();
      t_multi();
      t_same_cycle();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule